// File: doc/BRIEF.md
# Narrow-to-Wide Reshaping Memory

This block looks like a deep memory of narrow words with one write port and one read port, each with its own clock and enable. Inside, the words are packed several to a row in a shallower, wider array that has a write-enable per lane. The low bits of a logical address pick the lane inside a row, and the upper bits pick the row. A write places the narrow word in its lane of a wide word and enables only that lane. A read fetches the whole row and returns the lane that was addressed.

The default shape is 256 two-bit words held as 64 rows of 8 bits, which gives four lanes. The wide array is a behavioural register array, written so that a block RAM with lane enables can be inferred. A synchronous active-high reset clears only the read-side registers. The stored contents are never cleared.

Top module: `nw_reshape_mem`

## Requirements
- R1: The lane count is the wide width divided by the narrow width. The lane index is the low log2(lanes) bits of the logical address, and the row address is the logical address with those bits removed. Each of the 256 logical addresses holds its own value.
- R2: The wide write word holds the narrow data zero-extended and shifted left by lane index × narrow width. All bits outside the addressed lane are zero.
- R3: The write lane mask is one-hot, with bit i set for lane i = the write lane index.
- R4: A write changes only the addressed lane of its row. The other lanes of that row keep their contents.
- R5: A read with rd_en high at a rd_clk edge puts the addressed narrow word on rd_data after that edge, one cycle of latency.
- R6: The read lane index is registered on the same edge as the row address. Changing rd_addr while rd_en is low does not change rd_data.
- R7: While rd_en is low, rd_data holds its last value.
- R8: With wr_en low, wr_addr and wr_data have no effect on the contents.
- R9: A read and a write to the same row at the same edge return the row's contents from before the write (read-first). A later read sees the new data, and the other lanes are kept.
- R10: With rst high at a rd_clk edge, rd_data becomes 0. Stored contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Logical write address |
| wr_data | input | 2 | Narrow write data |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 8 | Logical read address |
| rd_data | output | 2 | Narrow read data, valid one cycle after a read |

## Verification
Several properties are checked by assertions on every cycle:
- the one-hot lane mask and the zero padding of the wide write word;
- that a write leaves the unmasked lanes of its row untouched;
- that rd_data and the lane register hold while reads are idle.

Only the bench's scenarios can show the rest. These are: the end-to-end address split across all 256 entries, the read-first result when a read and a write hit the same row, ignored disabled writes, and contents that survive reset. The bench compares rd_data against a flat narrow reference array on every cycle, under directed vectors and random traffic.

// File: rtl/nw_pkg.sv
package nw_pkg;
  localparam int DEF_LANE_W = 2;
  localparam int DEF_DEPTH  = 256;
  localparam int DEF_LANES  = 4;

  function automatic int clog2_min1(input int v);
    int r;
    r = $clog2(v);
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/nw_lane_pack.sv
module nw_lane_pack #(
  parameter int LANE_W    = 2,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 2,
  localparam int WIDE_W   = LANE_W * LANES
) (
  input  logic [LANE_BITS-1:0] wr_lane,
  input  logic [LANE_W-1:0]    wr_data,
  output logic [WIDE_W-1:0]    wr_word,
  output logic [LANES-1:0]     wr_mask
);
  always_comb begin
    wr_word = WIDE_W'(wr_data) << (int'(wr_lane) * LANE_W);
    wr_mask = LANES'(1) << wr_lane;
  end

  always_comb begin
    if (!$isunknown(wr_lane) && !$isunknown(wr_data)) begin
      // R3
      mask_onehot_chk: assert ($countones(wr_mask) == 1 && wr_mask[wr_lane]);
      for (int l = 0; l < LANES; l++) begin
        if (l == int'(wr_lane)) begin
          // R2
          lane_data_chk: assert (wr_word[l*LANE_W +: LANE_W] == wr_data);
        end else begin
          // R2
          lane_zero_chk: assert (wr_word[l*LANE_W +: LANE_W] == '0);
        end
      end
    end
  end
endmodule

// File: rtl/nw_wide_mem.sv
module nw_wide_mem #(
  parameter int LANE_W  = 2,
  parameter int LANES   = 4,
  parameter int DEPTH   = 64,
  parameter int RADDR_W = 6,
  localparam int WIDE_W = LANE_W * LANES
) (
  input  logic               wr_clk,
  input  logic               wr_en,
  input  logic [RADDR_W-1:0] wr_row,
  input  logic [WIDE_W-1:0]  wr_word,
  input  logic [LANES-1:0]   wr_mask,
  input  logic               rd_clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [RADDR_W-1:0] rd_row,
  output logic [WIDE_W-1:0]  rd_word
);
  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[wr_row][l] <= wr_word[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_row];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_keep
    // R4
    other_lane_kept_chk: assert property (@(posedge wr_clk) disable iff (rst)
      (wr_en && !wr_mask[g]) |=> (mem[$past(wr_row)][g] === $past(mem[wr_row][g])));
  end

  // R7
  word_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_en |=> $stable(rd_word));
endmodule

// File: rtl/nw_lane_pick.sv
module nw_lane_pick #(
  parameter int LANE_W    = 2,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 2,
  localparam int WIDE_W   = LANE_W * LANES
) (
  input  logic                 rd_clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [LANE_BITS-1:0] rd_lane,
  input  logic [WIDE_W-1:0]    rd_word,
  output logic [LANE_W-1:0]    rd_data
);
  logic [LANE_BITS-1:0] lane_q;

  always_ff @(posedge rd_clk) begin
    if (rst)        lane_q <= '0;
    else if (rd_en) lane_q <= rd_lane;
  end

  assign rd_data = rd_word[int'(lane_q)*LANE_W +: LANE_W];

  // R6
  lane_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_en |=> $stable(lane_q));
endmodule

// File: rtl/nw_reshape_mem.sv
module nw_reshape_mem #(
  parameter int LANE_W = nw_pkg::DEF_LANE_W,
  parameter int DEPTH  = nw_pkg::DEF_DEPTH,
  parameter int LANES  = nw_pkg::DEF_LANES,
  localparam int WIDE_W    = LANE_W * LANES,
  localparam int ROWS      = DEPTH / LANES,
  localparam int ADDR_W    = nw_pkg::clog2_min1(DEPTH),
  localparam int LANE_BITS = nw_pkg::clog2_min1(LANES),
  localparam int RADDR_W   = nw_pkg::clog2_min1(ROWS)
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_data
);
  logic [WIDE_W-1:0] wr_word;
  logic [LANES-1:0]  wr_mask;
  logic [WIDE_W-1:0] rd_word;

  nw_lane_pack #(.LANE_W(LANE_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_pack (
    .wr_lane (wr_addr[LANE_BITS-1:0]),
    .wr_data (wr_data),
    .wr_word (wr_word),
    .wr_mask (wr_mask)
  );

  nw_wide_mem #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(ROWS), .RADDR_W(RADDR_W)) u_mem (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_row  (wr_addr[ADDR_W-1:LANE_BITS]),
    .wr_word (wr_word),
    .wr_mask (wr_mask),
    .rd_clk  (rd_clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_row  (rd_addr[ADDR_W-1:LANE_BITS]),
    .rd_word (rd_word)
  );

  nw_lane_pick #(.LANE_W(LANE_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_pick (
    .rd_clk  (rd_clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_lane (rd_addr[LANE_BITS-1:0]),
    .rd_word (rd_word),
    .rd_data (rd_data)
  );

  // R7
  out_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R10
  reset_zero_chk: assert property (@(posedge rd_clk)
    rst |=> (rd_data == '0));
endmodule

// File: tb/sim_nw_reshape_mem.sv
module sim_nw_reshape_mem;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [1:0] wr_data = '0;
  logic [1:0] rd_data;

  int total = 0, bad = 0;
  logic [1:0] ref_mem [256];
  logic [1:0] exp_out = '0;

  always #2 clk = ~clk;

  nw_reshape_mem u0 (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {we, waddr, wdata, re, raddr}
  localparam logic [19:0] VEC [16] = '{
    {1'b1, 8'd4,   2'd3, 1'b0, 8'd0},
    {1'b1, 8'd5,   2'd1, 1'b1, 8'd4},
    {1'b1, 8'd6,   2'd2, 1'b1, 8'd5},
    {1'b1, 8'd7,   2'd1, 1'b1, 8'd6},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd7},
    {1'b1, 8'd7,   2'd2, 1'b1, 8'd7},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd7},
    {1'b0, 8'd7,   2'd0, 1'b1, 8'd4},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd7},
    {1'b1, 8'd255, 2'd3, 1'b1, 8'd0},
    {1'b1, 8'd0,   2'd2, 1'b1, 8'd255},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd0},
    {1'b1, 8'd252, 2'd1, 1'b1, 8'd253},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd252},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd254},
    {1'b0, 8'd0,   2'd0, 1'b1, 8'd4}
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; applies inputs, waits one cycle, checks output
  task automatic step(input logic we, input logic [7:0] wa, input logic [1:0] wd,
                      input logic re, input logic [7:0] ra, input string req);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    if (re) exp_out = ref_mem[ra];
    @(negedge clk);
    if (we) ref_mem[wa] = wd;
    chk(req, rd_data, exp_out);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 reset", rd_data, 2'd0);

    // R1 fill every logical address with a distinct pattern
    for (int i = 0; i < 256; i++)
      step(1'b1, 8'(i), 2'((i * 7 + 1) % 4), 1'b0, 8'd0, "R8 R7 idle during fill");
    // R1 read back all entries
    for (int i = 0; i < 256; i++)
      step(1'b0, 8'd0, 2'd0, 1'b1, 8'(i), "R1 R5 readback");

    // table: R4 R8 R9 corners
    for (int v = 0; v < 16; v++)
      step(VEC[v][19], VEC[v][18:11], VEC[v][10:9], VEC[v][8], VEC[v][7:0], "R4 R8 R9 table");

    // R6: read lane 1, then move rd_addr to another lane with rd_en low
    step(1'b1, 8'd9, 2'd2, 1'b0, 8'd0, "R6 setup");
    step(1'b1, 8'd10, 2'd1, 1'b0, 8'd0, "R6 setup");
    step(1'b0, 8'd0, 2'd0, 1'b1, 8'd9, "R6 read");
    step(1'b0, 8'd0, 2'd0, 1'b0, 8'd10, "R6 lane held");
    step(1'b0, 8'd0, 2'd0, 1'b0, 8'd11, "R7 hold");

    // R5 random traffic against the flat reference
    for (int k = 0; k < 2000; k++)
      step(1'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), "R5 R4 random");

    // R10: contents survive reset, output cleared
    step(1'b1, 8'd33, 2'd3, 1'b1, 8'd33, "R10 pre");
    step(1'b0, 8'd0, 2'd0, 1'b1, 8'd33, "R10 pre read");
    rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_out = '0;
    chk("R10 cleared", rd_data, 2'd0);
    step(1'b0, 8'd0, 2'd0, 1'b1, 8'd33, "R10 kept contents");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule